// File: doc/BRIEF.md
# Programmable Countdown Timer

This block is a per-processor countdown timer that raises a vectored event when its count runs out. Software loads three registers through a single write port: a starting count, a divider setting that picks the prescale ratio, and a timer entry that holds the event vector, a mask bit and a repeat bit. The present count is always visible on an output, so it can be read back at any time.

Writing the starting count restarts counting from that write. The prescaler divides the clock by a power of two. Each prescaled tick lowers the count by one. In single-shot mode the count stops at zero and the block raises one event. In repeat mode the count reloads, so events come at a fixed period. Each event is a one-cycle pulse that carries the 8-bit vector to the interrupt logic. A synchronous INIT input returns the block to its reset state.

Top module: `tick_timer`

## Requirements
- R1: After reset the count output reads 0 and no event is raised. The timer entry resets to 0x00010000 (masked, single-shot) and the divider resets to 0, which divides by 2.
- R2: A divider write keeps only bits 3, 1 and 0 of the data (bit 2 is dropped). These form the code {bit3, bit1, bit0}. The prescale ratio is 2 to the power ((code + 1) mod 8), so code 7 divides by 1 and codes 0 to 6 divide by 2 to 128.
- R3: A starting-count write (wr_sel_i = 0) loads the value N into the count output in the next cycle and restarts the prescaler. Writing again while counting starts the schedule over.
- R4: In single-shot mode (entry bit 17 = 0) the count falls by one every D cycles (D is the prescale ratio) and holds at 0. One event fires D*(N+1) cycles after the write, and no event follows it.
- R5: In repeat mode (entry bit 17 = 1) the count reads N - ((elapsed ticks) mod (N+1)). An event fires every D*(N+1) cycles.
- R6: In repeat mode with N = 0 no event ever fires, and the count stays at 0.
- R7: While entry bit 16 (mask) is set, no event fires, but the count keeps running. Clearing the mask after a single-shot expiry does not raise the missed event.
- R8: An event is a one-cycle pulse on fire_o. fire_vec_o holds bits 7:0 of the timer entry (wr_sel_i = 2) as they were at expiry.
- R9: A cycle with init_i high clears the count, stops counting and restores the R1 register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Synchronous INIT: return to the reset state |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 starting count, 1 divider, 2 timer entry, 3 ignored |
| wr_data_i | input | 32 | Write data |
| cnt_o | output | 32 | Present count |
| fire_o | output | 1 | One-cycle expiry event |
| fire_vec_o | output | 8 | Vector that goes with the event |

## Verification
All results are measured from the clock edge that takes a starting-count write, which is cycle 0. The count reads N in cycle 0 and N - m in cycle D*m. The event sits on the outputs in exactly cycle D*(N+1), and in each multiple of that in repeat mode, because a single register lies between the expiry and the pin. The bench drives each write on a falling edge and samples outputs on every following falling edge. At each sample it compares the count and the event against a model that uses only these cycle formulas, so an event that arrives one cycle early or late counts as a failure.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int VEC_W    = 8;
  localparam int SHIFT_W  = 3;
  localparam int MASK_BIT = 16;
  localparam int REP_BIT  = 17;
  localparam logic [31:0] ENTRY_RST = 32'h0001_0000;
  localparam logic [3:0]  DIV_KEEP  = 4'hB;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2
  } wr_sel_e;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int VW = VEC_W,
  parameter int SW = SHIFT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] start_o,
  output logic          load_o,
  output logic [SW-1:0] shift_o,
  output logic [VW-1:0] vec_o,
  output logic          masked_o,
  output logic          repeat_o
);
  logic [DW-1:0] start_q;
  logic [DW-1:0] entry_q;
  logic [3:0]    div_q;
  logic [SW-1:0] code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      entry_q <= DW'(ENTRY_RST);
      div_q   <= '0;
    end else if (init_i) begin
      start_q <= '0;
      entry_q <= DW'(ENTRY_RST);
      div_q   <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_COUNT: start_q <= wr_data_i;
        SEL_DIV:   div_q   <= wr_data_i[3:0] & DIV_KEEP;
        SEL_ENTRY: entry_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  // Divider code bits are not contiguous in the register
  assign code     = SW'({div_q[3], div_q[1:0]});
  assign shift_o  = code + SW'(1);
  assign load_o   = wr_en_i && !init_i && (wr_sel_i == SEL_COUNT);
  assign start_o  = start_q;
  assign vec_o    = entry_q[VW-1:0];
  assign masked_o = entry_q[MASK_BIT];
  assign repeat_o = entry_q[REP_BIT];

  a_r2_div_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !init_i && wr_sel_i == SEL_DIV) |=> (div_q == ($past(wr_data_i[3:0]) & 4'hB)));

  a_r9_init_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (masked_o && !repeat_o && shift_o == SW'(1) && start_o == '0));
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [SW-1:0] shift_i,
  output logic          tick_o
);
  localparam int PW = (1 << SW) - 1;

  logic [PW-1:0] pre_q;
  logic [PW:0]   full;
  logic [PW-1:0] lim;

  assign full   = ((PW+1)'(1) << shift_i) - (PW+1)'(1);
  assign lim    = full[PW-1:0];
  assign tick_o = run_i && ((pre_q & lim) == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (init_i || clr_i) pre_q <= '0;
    else if (run_i)          pre_q <= pre_q + PW'(1);
  end

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i && !init_i && lim != '0) |=> (!tick_o || shift_i != $past(shift_i)));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CW = 32,
  parameter int VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] start_i,
  input  logic          tick_i,
  input  logic          repeat_i,
  input  logic          masked_i,
  input  logic [VW-1:0] vec_i,
  output logic [CW-1:0] cnt_o,
  output logic          run_o,
  output logic          fire_o,
  output logic [VW-1:0] fire_vec_o
);
  logic [CW-1:0] cur_q;
  logic          run_q;
  logic          fire_q;
  logic [VW-1:0] vec_q;
  logic          expire;

  assign expire = tick_i && run_q && (cur_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0; run_q <= 1'b0; fire_q <= 1'b0; vec_q <= '0;
    end else if (init_i) begin
      cur_q <= '0; run_q <= 1'b0; fire_q <= 1'b0; vec_q <= '0;
    end else if (load_i) begin
      cur_q  <= load_val_i;
      run_q  <= 1'b1;
      fire_q <= 1'b0;
    end else begin
      // zero-length repeat period never raises an event
      fire_q <= expire && !masked_i && !(repeat_i && start_i == '0);
      if (expire) begin
        vec_q <= vec_i;
        if (repeat_i) cur_q <= start_i;
        else          run_q <= 1'b0;
      end else if (tick_i && run_q) begin
        cur_q <= cur_q - CW'(1);
      end
    end
  end

  assign cnt_o      = cur_q;
  assign run_o      = run_q;
  assign fire_o     = fire_q;
  assign fire_vec_o = vec_q;

  a_r4_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i && !init_i) |=> $stable(cur_q));

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q <= start_i);

  a_r6_zero_period_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repeat_i && start_i == '0) |=> !fire_o);

  a_r7_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_i |=> !fire_o);

  a_r8_vec_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (fire_vec_o == $past(vec_i)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int VW = VEC_W,
  parameter int SW = SHIFT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] cnt_o,
  output logic          fire_o,
  output logic [VW-1:0] fire_vec_o
);
  logic [DW-1:0] start;
  logic          load;
  logic [SW-1:0] shift;
  logic [VW-1:0] vec;
  logic          masked;
  logic          rep;
  logic          run;
  logic          tick;

  tick_regs #(.DW(DW), .VW(VW), .SW(SW)) u_regs (
    .clk_i, .rst_ni, .init_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .start_o(start), .load_o(load), .shift_o(shift), .vec_o(vec),
    .masked_o(masked), .repeat_o(rep)
  );

  tick_prescaler #(.SW(SW)) u_pre (
    .clk_i, .rst_ni, .init_i, .clr_i(load), .run_i(run),
    .shift_i(shift), .tick_o(tick)
  );

  tick_counter #(.CW(DW), .VW(VW)) u_cnt (
    .clk_i, .rst_ni, .init_i, .load_i(load), .load_val_i(wr_data_i),
    .start_i(start), .tick_i(tick), .repeat_i(rep), .masked_i(masked),
    .vec_i(vec), .cnt_o, .run_o(run), .fire_o, .fire_vec_o
  );

  a_r3_load_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt_o == $past(wr_data_i)));

  a_r8_single_pulse_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !rep && !load) |=> !fire_o);
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cnt;
  logic        fire;
  logic [7:0]  fire_vec;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .cnt_o(cnt),
    .fire_o(fire), .fire_vec_o(fire_vec)
  );

  typedef struct packed {
    logic [3:0]  div;
    logic [31:0] entry;
    logic [31:0] n;
    logic [31:0] d;
  } row_t;

  localparam row_t ROWS [7] = '{
    '{4'h0, 32'h0000_0041, 32'd3, 32'd2},
    '{4'hB, 32'h0000_0022, 32'd5, 32'd1},
    '{4'h1, 32'h0002_0033, 32'd2, 32'd4},
    '{4'h8, 32'h0000_0099, 32'd1, 32'd32},
    '{4'hA, 32'h0000_007F, 32'd0, 32'd128},
    '{4'h4, 32'h0000_0010, 32'd2, 32'd2},
    '{4'h3, 32'h0002_0005, 32'd1, 32'd16}
  };

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      summary();
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Walk span cycles, count fires and remember the cycle of the first one
  task automatic watch(int span, output int nfire, output int first);
    nfire = 0; first = -1;
    for (int j = 1; j <= span; j++) begin
      @(negedge clk);
      if (fire) begin
        nfire++;
        if (first < 0) first = j;
      end
    end
  endtask

  initial begin
    int nf, ff;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cnt == 0, "R1 count after reset", cnt, 0);
    check(fire == 0, "R1 no event after reset", fire, 0);
    rst_n = 1'b1;
    wr(2'd0, 32'd2);
    @(negedge clk);
    check(cnt == 2, "R1 default divide by 2 (cycle 1)", cnt, 2);
    @(negedge clk);
    check(cnt == 1, "R1 default divide by 2 (cycle 2)", cnt, 1);
    watch(10, nf, ff);
    check(nf == 0, "R1 default entry masked", nf, 0);

    // Table: R2 divider, R4 single-shot, R5 repeat, R8 vector
    for (int r = 0; r < 7; r++) begin
      row_t rw = ROWS[r];
      bit per = rw.entry[17];
      int n = int'(rw.n);
      int d = int'(rw.d);
      int p = d * (n + 1);
      int span = per ? 2 * p + 3 : p + 6;
      int cerr = 0, ferr = 0, verr = 0;
      longint ca = 0, ce = 0;
      wr(2'd1, 32'(rw.div));
      wr(2'd2, rw.entry);
      wr(2'd0, rw.n);
      check(cnt == rw.n, "R3 count loaded", cnt, rw.n);
      for (int j = 1; j <= span; j++) begin
        int ec;
        bit ef;
        @(negedge clk);
        if (per) begin
          ec = n - ((j / d) % (n + 1));
          ef = (n != 0) && (j % p == 0);
        end else begin
          ec = (j / d >= n) ? 0 : n - j / d;
          ef = (j == p);
        end
        if (cnt != 32'(ec) && cerr == 0) begin cerr = 1; ca = cnt; ce = ec; end
        if (fire != ef) ferr++;
        if (fire && fire_vec != rw.entry[7:0]) verr++;
      end
      check(cerr == 0, per ? "R2 R5 count sequence" : "R2 R4 count sequence", ca, ce);
      check(ferr == 0, per ? "R5 event timing" : "R4 event timing", ferr, 0);
      check(verr == 0, "R8 event vector", verr, 0);
    end

    // R3 restart mid-count
    wr(2'd1, 32'hB);
    wr(2'd2, 32'h44);
    wr(2'd0, 32'd5);
    repeat (3) @(negedge clk);
    check(cnt == 2, "R3 count before restart", cnt, 2);
    wr(2'd0, 32'd5);
    check(cnt == 5, "R3 count after restart", cnt, 5);
    watch(12, nf, ff);
    check(nf == 1 && ff == 6, "R3 event at restart+6", ff, 6);

    // R6 zero repeat period
    wr(2'd2, 32'h0002_0055);
    wr(2'd0, 32'd0);
    watch(20, nf, ff);
    check(nf == 0, "R6 no event", nf, 0);
    check(cnt == 0, "R6 count stays 0", cnt, 0);

    // R7 mask
    wr(2'd2, 32'h0001_0066);
    wr(2'd0, 32'd3);
    repeat (2) @(negedge clk);
    check(cnt == 1, "R7 count runs while masked", cnt, 1);
    watch(8, nf, ff);
    check(nf == 0, "R7 masked no event", nf, 0);
    wr(2'd2, 32'h66);
    watch(10, nf, ff);
    check(nf == 0, "R7 unmask after expiry no event", nf, 0);
    check(cnt == 0, "R7 count held 0", cnt, 0);

    // R9 INIT
    wr(2'd2, 32'h0002_0011);
    wr(2'd0, 32'd3);
    repeat (2) @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    check(cnt == 0, "R9 count cleared", cnt, 0);
    watch(20, nf, ff);
    check(nf == 0, "R9 stopped", nf, 0);
    wr(2'd0, 32'd1);
    @(negedge clk);
    check(cnt == 1, "R9 divider back to 2", cnt, 1);
    watch(10, nf, ff);
    check(nf == 0, "R9 entry masked again", nf, 0);

    summary();
  end
endmodule